// File: doc/BRIEF.md
# Match-Compare Operating-System Timer with Watchdog

This block is a memory-mapped timer for operating-system scheduling. A 32-bit up-counter advances on each cycle where a tick-enable input is high. Four 32-bit compare registers are checked against the counter. When the counter takes a value equal to a compare register, that channel records an event, provided its interrupt enable is set. Each recorded event drives the channel's own interrupt line until software clears it by writing a one to its status bit.

Compare channel 3 can also act as a one-shot watchdog. If bit 0 of the watchdog-arm register is set when channel 3 matches, the block issues a single-cycle system-reset request and disarms itself. Software re-arms the watchdog after it fires, and normally moves the channel 3 compare value ahead of the counter before the counter reaches it.

Access is through a simple single-cycle register port. Writes take effect on the clock edge. Reads are combinational from the address.

Top module: `ostm_top`

## Requirements
- R1: After reset, the counter, all four compare registers, the status bits, the interrupt enables and the watchdog-arm bit read as zero, and `irq` and `wdog_rst_req` are low.
- R2: The counter (offset 0x10) increments by one on each clock edge where `tick_en` is high. It holds its value when `tick_en` is low, and it wraps from 0xFFFFFFFF to 0.
- R3: A write to offset 0x10 loads the counter with the written data, and this takes priority over a tick in the same cycle. Counting resumes from the loaded value.
- R4: Compare register k sits at offset 4*k (k = 0..3). Status bit k (offset 0x14, bits 3:0) is set on the same edge on which the counter takes a value exactly equal to compare register k, whether by a tick or by a load, when interrupt-enable bit k is one. A counter that holds at the matching value does not set the bit again.
- R5: A match on a channel whose interrupt-enable bit is zero leaves its status bit and its `irq` line unchanged.
- R6: Output `irq[k]` is high exactly while status bit k is set.
- R7: A write to the status register clears only the bits written as one. Writing zeros has no effect. A match that sets a bit in the same cycle wins over the clear.
- R8: The interrupt-enable register (offset 0x1C) keeps only the low 12 bits of a write. Bits 3:0 gate channels 0..3.
- R9: When channel 3 matches while the watchdog-arm bit (offset 0x18, bit 0) is one, `wdog_rst_req` is high for exactly one cycle, on the same edge as the match. The arm bit returns to zero. This happens whatever the interrupt enables hold.
- R10: The watchdog-arm register keeps only bit 0 of a write. With the bit at zero, a channel 3 match raises no reset request.
- R11: A read of any offset outside the eight listed registers returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counter advance enable for this cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq | output | 4 | Per-channel interrupt lines |
| wdog_rst_req | output | 1 | One-cycle system-reset request |

## Verification
The compare function is driven with several counter start points and tick counts. These include a match reached by counting, a match taken directly by a counter load, a match after wrap-around through zero, and a compare value just behind or just beyond the final count. Together they separate a correct equality test from an off-by-one or a greater-or-equal test. Gated channels, with their enable bit cleared, show that the enable mask acts and not the match alone. Directed sequences cover partial status clears, a clear colliding with a new match, load priority over tick, and the watchdog firing once and then staying silent once disarmed.

// File: rtl/ostm_pkg.sv
package ostm_pkg;
    localparam int unsigned CH_NUM_DEF  = 4;
    localparam int unsigned DATA_W_DEF  = 32;
    localparam int unsigned ADDR_W_DEF  = 8;
    localparam int unsigned IEN_W_DEF   = 12;
    localparam int unsigned MATCH_STEP  = 4;

    localparam logic [7:0] OFS_COUNT = 8'h10;
    localparam logic [7:0] OFS_STAT  = 8'h14;
    localparam logic [7:0] OFS_WARM  = 8'h18;
    localparam logic [7:0] OFS_IEN   = 8'h1C;
endpackage

// File: rtl/ostm_counter.sv
module ostm_counter #(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    output logic [DW-1:0] cnt_q,
    output logic [DW-1:0] cnt_d,
    output logic          moved
);
    // A load outranks a tick; either one counts as the counter taking a value.
    always_comb begin
        cnt_d = cnt_q;
        moved = 1'b0;
        if (load) begin
            cnt_d = load_val;
            moved = 1'b1;
        end else if (tick) begin
            cnt_d = cnt_q + DW'(1);
            moved = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/ostm_cmp.sv
module ostm_cmp #(
    parameter int unsigned DW  = 32,
    parameter int unsigned NCH = 4
) (
    input  logic                    moved,
    input  logic [DW-1:0]           cnt_next,
    input  logic [NCH-1:0][DW-1:0]  cmp_val,
    output logic [NCH-1:0]          hit
);
    // Compare against the value being taken, so the event lands on the same edge.
    for (genvar k = 0; k < NCH; k++) begin : g_cmp
        assign hit[k] = moved && (cnt_next == cmp_val[k]);
    end
endmodule

// File: rtl/ostm_top.sv
module ostm_top
    import ostm_pkg::*;
#(
    parameter int unsigned NCH   = CH_NUM_DEF,
    parameter int unsigned DW    = DATA_W_DEF,
    parameter int unsigned AW    = ADDR_W_DEF,
    parameter int unsigned IEN_W = IEN_W_DEF
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick_en,
    input  logic           reg_wr,
    input  logic [AW-1:0]  reg_addr,
    input  logic [DW-1:0]  reg_wdata,
    output logic [DW-1:0]  reg_rdata,
    output logic [NCH-1:0] irq,
    output logic           wdog_rst_req
);
    localparam int unsigned WD_CH = NCH - 1;

    typedef struct packed {
        logic [NCH-1:0][DW-1:0] cmp;
        logic [NCH-1:0]         stat;
        logic [IEN_W-1:0]       ien;
        logic                   warm;
        logic                   rreq;
    } state_t;

    state_t s_d, s_q;

    logic          cnt_load;
    logic [DW-1:0] cnt_q, cnt_d;
    logic          cnt_moved;
    logic [NCH-1:0] hit;

    assign cnt_load = reg_wr && (reg_addr == AW'(OFS_COUNT));

    ostm_counter #(.DW(DW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_en),
        .load     (cnt_load),
        .load_val (reg_wdata),
        .cnt_q    (cnt_q),
        .cnt_d    (cnt_d),
        .moved    (cnt_moved)
    );

    ostm_cmp #(.DW(DW), .NCH(NCH)) u_cmp (
        .moved    (cnt_moved),
        .cnt_next (cnt_d),
        .cmp_val  (s_q.cmp),
        .hit      (hit)
    );

    always_comb begin
        s_d      = s_q;
        s_d.rreq = 1'b0;
        if (reg_wr) begin
            for (int k = 0; k < NCH; k++) begin
                if (reg_addr == AW'(k * MATCH_STEP)) s_d.cmp[k] = reg_wdata;
            end
            if (reg_addr == AW'(OFS_STAT)) s_d.stat = s_q.stat & ~reg_wdata[NCH-1:0];
            if (reg_addr == AW'(OFS_IEN))  s_d.ien  = reg_wdata[IEN_W-1:0];
            if (reg_addr == AW'(OFS_WARM)) s_d.warm = reg_wdata[0];
        end
        // New events are merged after the clear, so a simultaneous match survives.
        s_d.stat = s_d.stat | (hit & s_q.ien[NCH-1:0]);
        if (hit[WD_CH] && s_q.warm) begin
            s_d.rreq = 1'b1;
            s_d.warm = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        reg_rdata = '0;
        for (int k = 0; k < NCH; k++) begin
            if (reg_addr == AW'(k * MATCH_STEP)) reg_rdata = s_q.cmp[k];
        end
        if (reg_addr == AW'(OFS_COUNT)) reg_rdata = cnt_q;
        if (reg_addr == AW'(OFS_STAT))  reg_rdata = DW'(s_q.stat);
        if (reg_addr == AW'(OFS_WARM))  reg_rdata = DW'(s_q.warm);
        if (reg_addr == AW'(OFS_IEN))   reg_rdata = DW'(s_q.ien);
    end

    assign irq          = s_q.stat;
    assign wdog_rst_req = s_q.rreq;
endmodule

// File: rtl/ostm_chk.sv
module ostm_chk
    import ostm_pkg::*;
#(
    parameter int unsigned NCH = CH_NUM_DEF,
    parameter int unsigned DW  = DATA_W_DEF,
    parameter int unsigned AW  = ADDR_W_DEF
) (
    input logic           clk,
    input logic           rst_n,
    input logic           tick_en,
    input logic           reg_wr,
    input logic [AW-1:0]  reg_addr,
    input logic [DW-1:0]  reg_wdata,
    input logic [DW-1:0]  cnt,
    input logic [NCH-1:0] irq,
    input logic [NCH-1:0] ien,
    input logic           warm,
    input logic           rst_req
);
    logic cnt_wr, stat_wr;
    assign cnt_wr  = reg_wr && (reg_addr == AW'(OFS_COUNT));
    assign stat_wr = reg_wr && (reg_addr == AW'(OFS_STAT));

    p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(tick_en) && !$past(cnt_wr) |-> cnt == $past(cnt) + DW'(1));

    p_cnt_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(cnt_wr) |-> cnt == $past(reg_wdata));

    for (genvar k = 0; k < NCH; k++) begin : g_bit
        p_set_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && $rose(irq[k]) |-> $past(ien[k]));

        p_clear_by_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && $fell(irq[k]) |-> $past(stat_wr) && $past(reg_wdata[k]));
    end

    p_req_disarms_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && rst_req |-> $past(warm) && !warm);

    p_req_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);
endmodule

bind ostm_top ostm_chk #(.NCH(NCH), .DW(DW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .cnt       (cnt_q),
    .irq       (irq),
    .ien       (s_q.ien[NCH-1:0]),
    .warm      (s_q.warm),
    .rst_req   (wdog_rst_req)
);

// File: tb/tb_ostm_top.sv
module tb_ostm_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic [3:0]  irq;
    logic        wdog_rst_req;

    int nchk = 0;
    int nfail = 0;
    int pulses = 0;

    always #2 clk = ~clk;

    ostm_top dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .wdog_rst_req(wdog_rst_req)
    );

    always @(negedge clk) if (wdog_rst_req) pulses++;

    typedef struct packed {
        logic [1:0]  ch;
        logic [3:0]  ien;
        logic [31:0] start;
        logic [7:0]  ticks;
        logic [31:0] mval;
        logic [3:0]  exp_st;
        logic [31:0] exp_cnt;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 4'h1, 32'h0000_0100, 8'd10, 32'h0000_0105, 4'h1, 32'h0000_010A},
        '{2'd1, 4'h2, 32'h0000_0100, 8'd4,  32'h0000_0105, 4'h0, 32'h0000_0104},
        '{2'd2, 4'h4, 32'hFFFF_FFFE, 8'd4,  32'h0000_0001, 4'h4, 32'h0000_0002},
        '{2'd3, 4'h0, 32'h0000_0050, 8'd5,  32'h0000_0052, 4'h0, 32'h0000_0055},
        '{2'd1, 4'h2, 32'h0000_0077, 8'd0,  32'h0000_0077, 4'h2, 32'h0000_0077},
        '{2'd3, 4'h8, 32'hFFFF_FFF0, 8'd16, 32'h0000_0000, 4'h8, 32'h0000_0000},
        '{2'd0, 4'h1, 32'h0000_0200, 8'd3,  32'h0000_01FF, 4'h0, 32'h0000_0203},
        '{2'd2, 4'h4, 32'hABCD_0000, 8'd1,  32'hABCD_0001, 4'h4, 32'hABCD_0001}
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic ticks(input int n);
        if (n > 0) begin
            @(negedge clk);
            tick_en = 1'b1;
            repeat (n) @(negedge clk);
            tick_en = 1'b0;
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog timeout");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 32; a += 4) begin
            rd(8'(a), v);
            chk("R1 reset register", v, 32'h0);
        end
        chk("R1 irq after reset", {28'h0, irq}, 32'h0);
        chk("R1 reset request low", {31'h0, wdog_rst_req}, 32'h0);
        repeat (3) @(negedge clk);
        rd(8'h10, v);
        chk("R2 counter holds without tick", v, 32'h0);

        // Table walk: R2 counting, R4/R5 match and gating, R6 irq
        for (int i = 0; i < NV; i++) begin
            wr(8'h1C, {28'h0, VECS[i].ien});
            wr({4'h0, VECS[i].ch, 2'b00}, VECS[i].mval);
            wr(8'h14, 32'hF);
            wr(8'h10, VECS[i].start);
            ticks(int'(VECS[i].ticks));
            rd(8'h14, v);
            chk("R4/R5 status after vector", v, {28'h0, VECS[i].exp_st});
            chk("R6 irq after vector", {28'h0, irq}, {28'h0, VECS[i].exp_st});
            rd(8'h10, v);
            chk("R2 counter after vector", v, VECS[i].exp_cnt);
        end

        // R4: holding at the matching value does not set the bit again
        wr(8'h14, 32'hF);
        repeat (4) @(negedge clk);
        rd(8'h14, v);
        chk("R4 no refire while counter holds", v, 32'h0);

        // R3: load beats tick, then counting resumes
        @(negedge clk);
        tick_en = 1'b1; reg_wr = 1'b1; reg_addr = 8'h10; reg_wdata = 32'h40;
        @(negedge clk);
        reg_wr = 1'b0;
        #1 chk("R3 load wins over tick", reg_rdata, 32'h40);
        @(negedge clk);
        tick_en = 1'b0;
        #1 chk("R3 counting resumes from load", reg_rdata, 32'h41);

        // R8: interrupt enable width
        wr(8'h1C, 32'hFFFF_FFFF);
        rd(8'h1C, v);
        chk("R8 enable keeps 12 bits", v, 32'h0000_0FFF);

        // R7: partial clears
        wr(8'h00, 32'h1000); wr(8'h04, 32'h1001); wr(8'h08, 32'h1002); wr(8'h0C, 32'h1003);
        wr(8'h14, 32'hF);
        wr(8'h10, 32'h1000);
        ticks(3);
        rd(8'h14, v);
        chk("R4 all four channels set", v, 32'hF);
        wr(8'h14, 32'h5);
        rd(8'h14, v);
        chk("R7 clear only written ones", v, 32'hA);
        chk("R6 irq follows partial clear", {28'h0, irq}, 32'hA);
        wr(8'h14, 32'h0);
        rd(8'h14, v);
        chk("R7 zero write leaves status", v, 32'hA);
        wr(8'h14, 32'hF);
        rd(8'h14, v);
        chk("R7 full clear", v, 32'h0);

        // R7: match in the same cycle as a clear wins
        wr(8'h1C, 32'h1);
        wr(8'h00, 32'h500);
        wr(8'h10, 32'h4FF);
        @(negedge clk);
        tick_en = 1'b1; reg_wr = 1'b1; reg_addr = 8'h14; reg_wdata = 32'h1;
        @(negedge clk);
        tick_en = 1'b0; reg_wr = 1'b0;
        rd(8'h14, v);
        chk("R7 set wins over clear", v, 32'h1);

        // R10: arm register keeps bit 0 only
        wr(8'h18, 32'hFFFF_FFFE);
        rd(8'h18, v);
        chk("R10 arm ignores upper bits", v, 32'h0);
        wr(8'h18, 32'hFFFF_FFFF);
        rd(8'h18, v);
        chk("R10 arm bit 0 kept", v, 32'h1);

        // R9: watchdog fires once, regardless of enables
        wr(8'h1C, 32'h0);
        wr(8'h14, 32'hF);
        wr(8'h0C, 32'h3000);
        pulses = 0;
        wr(8'h10, 32'h2FFE);
        ticks(3);
        @(negedge clk);
        chk("R9 one reset pulse", 32'(pulses), 32'd1);
        rd(8'h18, v);
        chk("R9 arm cleared after firing", v, 32'h0);
        rd(8'h14, v);
        chk("R5 gated channel 3 status", v, 32'h0);
        wr(8'h10, 32'h2FFE);
        ticks(3);
        @(negedge clk);
        chk("R10 disarmed watchdog silent", 32'(pulses), 32'd1);

        // R11: unmapped offsets
        rd(8'h20, v); chk("R11 unmapped 0x20", v, 32'h0);
        rd(8'h24, v); chk("R11 unmapped 0x24", v, 32'h0);
        rd(8'hFC, v); chk("R11 unmapped 0xFC", v, 32'h0);
        rd(8'h02, v); chk("R11 unaligned 0x02", v, 32'h0);

        summary();
        $finish;
    end
endmodule